// File: doc/BRIEF.md
# Reversible-Gate Two-Input Programmable Logic Cell

This block is a small programmable logic element for two operands, `p` and `q`. A 4-bit configuration code selects the function. The code is the function's truth table, so each of the sixteen two-input Boolean functions has exactly one code. No truth-table storage is used to evaluate the function. All fourteen non-constant functions come out of one fixed 3-in/3-out reversible permutation gate. A per-code steering table decides what each gate input receives: an operand, an inverted operand, or a constant. The same table decides which gate output becomes the result. The two constant functions do not use the gate; they drive a literal 0 or 1.

The configuration code is captured into a register by a one-cycle load strobe. The path from `p`/`q` to `f` is purely combinational, so the result tracks the operands within the same cycle. `f_valid` reports that a code has been loaded since reset. Until then `f` is held low.

The fixed gate maps the input index {a,b,c} (a is the MSB) to the output index {o2,o1,o0} (o2 is the MSB) as follows: 0→1, 1→5, 2→3, 3→0, 4→4, 5→2, 6→7, 7→6. As one example, steering a=p, b=0, c=q and reading o1 gives p AND q.

Top module: `rev_lut2_cell`

## Requirements
- R1: While reset is held and after reset is released, and before any load, `f_valid` is 0 and `f` is 0.
- R2: When `cfg_load` is 1 at a rising clock edge, `cfg_code` is captured at that edge. The new function appears on `f` and `f_valid` is 1 from that edge on. Before that edge, `f` still follows the previous function.
- R3: While `cfg_load` is 0, changes on `cfg_code` have no effect on `f`.
- R4: Once valid, `f` equals bit (3 − (2·p + q)) of the loaded code. Bit 3 is f(0,0), bit 2 is f(0,1), bit 1 is f(1,0) and bit 0 is f(1,1). AND is code 1. `f` responds to `p` and `q` in the same cycle.
- R5: Code 0 gives `f` = 0 and code 15 gives `f` = 1 for every operand pair, without using the gate.
- R6: Codes 3, 5, 12 and 10 give p, q, NOT p and NOT q respectively.
- R7: Code 6 gives p XOR q and code 9 gives p XNOR q.
- R8: Every non-constant code (1 to 14) is produced through the single fixed permutation gate. The gate's inputs are steered only from {p, NOT p, q, NOT q, 0, 1}, and one of its three outputs is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for the function code |
| cfg_code | input | 4 | Truth-table code of the function to load |
| p | input | 1 | First operand |
| q | input | 1 | Second operand |
| f | output | 1 | Function result f(p,q) |
| f_valid | output | 1 | A code has been loaded since reset |

## Verification
The bench builds the cell with its default 4-bit code and 3-wide gate. At that size the whole function space is small: all sixteen codes against all four operand pairs is only 64 points, so the bench sweeps every point. Each expected value is taken from the truth-table bit the code selects. The bench also places load strobes so that a result can be observed just before and just after the capturing edge. Between loads it changes `cfg_code` with no strobe, which exposes any leak of the raw input into the result.

// File: rtl/rlut_pkg.sv
package rlut_pkg;

  localparam int OPND_N = 2;
  localparam int CODE_W = 1 << OPND_N;
  localparam int GATE_W = 3;
  localparam int OSEL_W = $clog2(GATE_W);

  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_ONE  = 3'd1,
    SRC_P    = 3'd2,
    SRC_NP   = 3'd3,
    SRC_Q    = 3'd4,
    SRC_NQ   = 3'd5
  } src_e;

  typedef struct packed {
    logic              gate_en;
    logic              konst;
    src_e              sa;
    src_e              sb;
    src_e              sc;
    logic [OSEL_W-1:0] osel;
  } route_t;

  function automatic route_t mk_route(logic en, logic k, src_e a, src_e b,
                                      src_e c, logic [OSEL_W-1:0] o);
    route_t r;
    r.gate_en = en;
    r.konst   = k;
    r.sa      = a;
    r.sb      = b;
    r.sc      = c;
    r.osel    = o;
    return r;
  endfunction

  // fixed reversible permutation, index {a,b,c} -> {o2,o1,o0}
  function automatic logic [GATE_W-1:0] gate_perm(logic [GATE_W-1:0] x);
    logic [GATE_W-1:0] y;
    case (x)
      3'd0:    y = 3'd1;
      3'd1:    y = 3'd5;
      3'd2:    y = 3'd3;
      3'd3:    y = 3'd0;
      3'd4:    y = 3'd4;
      3'd5:    y = 3'd2;
      3'd6:    y = 3'd7;
      default: y = 3'd6;
    endcase
    return y;
  endfunction

  // truth-table lookup: MSB of the code is f(0,0), LSB is f(1,1)
  function automatic logic tt_bit(logic [CODE_W-1:0] code, logic pp, logic qq);
    int idx;
    idx = (CODE_W - 1) - (2 * int'(pp) + int'(qq));
    return code[idx];
  endfunction

endpackage

// File: rtl/rlut_route_table.sv
module rlut_route_table
  import rlut_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output route_t            route
);

  always_comb begin
    case (code)
      4'd0:  route = mk_route(1'b0, 1'b0, SRC_ZERO, SRC_ZERO, SRC_ZERO, 2'd0);
      4'd15: route = mk_route(1'b0, 1'b1, SRC_ZERO, SRC_ZERO, SRC_ZERO, 2'd0);
      // conjunction family on o1 with b=0: o1 = a & c
      4'd1:  route = mk_route(1'b1, 1'b0, SRC_P,    SRC_ZERO, SRC_Q,    2'd1);
      4'd2:  route = mk_route(1'b1, 1'b0, SRC_P,    SRC_ZERO, SRC_NQ,   2'd1);
      4'd4:  route = mk_route(1'b1, 1'b0, SRC_NP,   SRC_ZERO, SRC_Q,    2'd1);
      4'd8:  route = mk_route(1'b1, 1'b0, SRC_NP,   SRC_ZERO, SRC_NQ,   2'd1);
      // disjunction family on o1 with b=1: o1 = a | ~c
      4'd7:  route = mk_route(1'b1, 1'b0, SRC_P,    SRC_ONE,  SRC_NQ,   2'd1);
      4'd11: route = mk_route(1'b1, 1'b0, SRC_P,    SRC_ONE,  SRC_Q,    2'd1);
      4'd13: route = mk_route(1'b1, 1'b0, SRC_Q,    SRC_ONE,  SRC_P,    2'd1);
      4'd14: route = mk_route(1'b1, 1'b0, SRC_NP,   SRC_ONE,  SRC_Q,    2'd1);
      // pass-through on o1 with a=1, b=0: o1 = c
      4'd3:  route = mk_route(1'b1, 1'b0, SRC_ONE,  SRC_ZERO, SRC_P,    2'd1);
      4'd5:  route = mk_route(1'b1, 1'b0, SRC_ONE,  SRC_ZERO, SRC_Q,    2'd1);
      4'd10: route = mk_route(1'b1, 1'b0, SRC_ONE,  SRC_ZERO, SRC_NQ,   2'd1);
      4'd12: route = mk_route(1'b1, 1'b0, SRC_ONE,  SRC_ZERO, SRC_NP,   2'd1);
      // parity on o2 with b=0: o2 = a ^ c
      4'd6:  route = mk_route(1'b1, 1'b0, SRC_P,    SRC_ZERO, SRC_Q,    2'd2);
      default: route = mk_route(1'b1, 1'b0, SRC_P,  SRC_ZERO, SRC_NQ,   2'd2);
    endcase
  end

endmodule

// File: rtl/rlut_steer.sv
module rlut_steer
  import rlut_pkg::*;
(
  input  src_e sel,
  input  logic p,
  input  logic q,
  output logic o
);

  always_comb begin
    case (sel)
      SRC_ONE: o = 1'b1;
      SRC_P:   o = p;
      SRC_NP:  o = ~p;
      SRC_Q:   o = q;
      SRC_NQ:  o = ~q;
      default: o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rlut_core_gate.sv
module rlut_core_gate
  import rlut_pkg::*;
(
  input  logic [GATE_W-1:0] gin,
  output logic [GATE_W-1:0] gout
);

  assign gout = gate_perm(gin);

endmodule

// File: rtl/rev_lut2_cell.sv
module rev_lut2_cell
  import rlut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              p,
  input  logic              q,
  output logic              f,
  output logic              f_valid
);

  logic [CODE_W-1:0] code_q;
  logic              valid_q;
  route_t            route;
  src_e              sel_v [GATE_W];
  logic [GATE_W-1:0] steer_v;
  logic [GATE_W-1:0] gate_in;
  logic [GATE_W-1:0] gate_out;
  logic              gate_active;
  logic              gate_bit;

  // R2 R3: code register, loaded only by the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else if (cfg_load) begin
      code_q  <= cfg_code;
      valid_q <= 1'b1;
    end
  end

  rlut_route_table u_table (
    .code  (code_q),
    .route (route)
  );

  assign sel_v[0] = route.sc;
  assign sel_v[1] = route.sb;
  assign sel_v[2] = route.sa;

  // R8: one steering mux per gate input, bit 2 = a, bit 0 = c
  for (genvar g = 0; g < GATE_W; g++) begin : g_steer
    rlut_steer u_steer (
      .sel (sel_v[g]),
      .p   (p),
      .q   (q),
      .o   (steer_v[g])
    );
  end

  assign gate_active = route.gate_en;
  assign gate_in     = gate_active ? steer_v : '0;

  rlut_core_gate u_gate (
    .gin  (gate_in),
    .gout (gate_out)
  );

  assign gate_bit = gate_out[route.osel];

  always_comb begin
    if (!valid_q)         f = 1'b0;
    else if (gate_active) f = gate_bit;
    else                  f = route.konst;
  end

  assign f_valid = valid_q;

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (f_valid && code_q == $past(cfg_code)));

  a_r3_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(code_q));

  a_r4_truth_table: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid |-> (f == tt_bit(code_q, p, q)));

  a_r5_const_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && code_q == 4'd0) |-> !f);

  a_r5_const_one: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && code_q == 4'd15) |-> f);

  a_r6_follow_p: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && code_q == 4'd3) |-> (f == p));

  a_r7_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && code_q == 4'd6) |-> (f == (p ^ q)));

  a_r8_idle_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !f_valid |-> !f);

endmodule

// File: tb/rev_lut2_cell_tb.sv
`timescale 1ns/1ps
module rev_lut2_cell_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_load;
  logic [3:0] cfg_code;
  logic       p;
  logic       q;
  logic       f;
  logic       f_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rev_lut2_cell u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_code (cfg_code),
    .p        (p),
    .q        (q),
    .f        (f),
    .f_valid  (f_valid)
  );

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // expected result: code bit (3 - (2p+q))
  function automatic logic ref_f(int code, int pp, int qq);
    return 1'((code >> (3 - (2 * pp + qq))) & 1);
  endfunction

  task automatic load_code(int c);
    @(negedge clk);
    cfg_code = 4'(c);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic sweep(int c, string tag);
    for (int k = 0; k < 4; k++) begin
      p = 1'(k >> 1);
      q = 1'(k & 1);
      #0.4;
      check(tag, f, ref_f(c, k >> 1, k & 1));
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    cfg_load = 1'b0;
    cfg_code = 4'd0;
    p        = 1'b0;
    q        = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", f_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", f_valid, 1'b0);
    for (int k = 0; k < 4; k++) begin
      p = 1'(k >> 1);
      q = 1'(k & 1);
      #0.4;
      check("R1 R8 f quiet before load", f, 1'b0);
    end
    cfg_code = 4'd15;
    @(negedge clk);
    check("R3 no strobe keeps invalid", f_valid, 1'b0);
    check("R3 no strobe keeps f low", f, 1'b0);

    // full sweep: every code against every operand pair
    for (int c = 0; c < 16; c++) begin
      load_code(c);
      check("R2 valid after load", f_valid, 1'b1);
      if (c == 0 || c == 15)                       sweep(c, "R5 constant code");
      else if (c == 3 || c == 5 || c == 10 || c == 12) sweep(c, "R6 single operand code");
      else if (c == 6 || c == 9)                   sweep(c, "R7 parity code");
      else                                         sweep(c, "R4 R8 gate code");
    end

    // AND specifically (code 1)
    load_code(1);
    p = 1'b1; q = 1'b1; #0.4; check("R4 AND 1,1", f, 1'b1);
    p = 1'b1; q = 1'b0; #0.4; check("R4 AND 1,0", f, 1'b0);

    // R3: raw code changes without strobe are ignored
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cfg_code = 4'(c);
      @(negedge clk);
      sweep(1, "R3 code ignored without strobe");
    end

    // R2: old function holds until the capturing edge
    load_code(6);
    @(negedge clk);
    cfg_code = 4'd9;
    cfg_load = 1'b1;
    p = 1'b0; q = 1'b0;
    #0.4;
    check("R2 old function before edge", f, 1'b0);
    @(posedge clk);
    #0.4;
    check("R2 new function after edge", f, 1'b1);
    @(negedge clk);
    cfg_load = 1'b0;
    sweep(9, "R2 R7 xnor after reload");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule